// File: doc/BRIEF.md
# Graphics Engine Interrupt Aggregator

This block collects completion and resource events from a graphics-style engine and presents them to a processor as a single interrupt line. Two sources are pulse events: a rendered frame finishing and the binning stage finishing its final flush. Each pulse is latched into a pending bit. The third source is a level condition that reports the binner running out of memory. Its pending bit stays high for as long as the condition is present.

Software reaches the block through a simple synchronous register port with three 32-bit locations. The pending register is acknowledged by writing ones to it. The enable mask has no plain write location. Ones are merged into it through a set alias, and ones are removed from it through a clear alias. Reading either alias returns the mask. The interrupt output is registered and is high whenever at least one pending bit is also enabled.

Top module: `gfx_irq_ctrl`

## Requirements
- R1: After a synchronous reset, the pending register reads 0, the enable mask reads 0, and `irq_o` is low.
- R2: A write to byte address 0x0 clears every pending bit whose written bit is 1. Bits written as 0 keep their value.
- R3: A write to byte address 0x4 sets every enable bit whose written bit is 1. Zero bits in the written value leave the mask unchanged.
- R4: A write to byte address 0x8 clears every enable bit whose written bit is 1. Zero bits in the written value leave the mask unchanged.
- R5: A read of address 0x4 or address 0x8 returns the enable mask. A read of 0x0 returns the pending register. Bits 31..3 always read as 0. `bus_rdata` is valid on the clock edge after the read strobe is sampled.
- R6: Pending bit 0 is frame done and pending bit 1 is flush done. Each is set by a one-cycle pulse and holds until it is cleared. Each is set whether or not its enable bit is set.
- R7: Pending bit 2 is out of memory. It is set on every edge where its level input is high, so a write-1 acknowledge cannot clear it while the level is high. After the level drops, the bit stays set until it is acknowledged.
- R8: If a source asserts in the same cycle as a write-1 clear of its pending bit, the bit remains set.
- R9: `irq_o` is registered. It equals the OR of (pending AND enable) as that value stood one clock earlier.
- R10: A single write of 0x7 to address 0x0 clears all three pending bits, provided the out-of-memory level is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| evt_frame_done | input | 1 | Frame-finished pulse |
| evt_flush_done | input | 1 | Binning-flush-finished pulse |
| lvl_out_of_mem | input | 1 | Binner out-of-memory level |
| irq_o | output | 1 | Registered interrupt request |

## Verification
A source pulse or a register write takes effect in the pending register or the enable mask on the edge that samples it. `irq_o` follows one edge later. Read data appears on the edge after the read strobe. The bench therefore drives each stimulus for exactly one cycle and lets one more edge pass before it samples `irq_o`. Every register value is fetched through a read whose data is taken at the falling edge after the capturing rising edge. A directed sequence checks the one-edge interrupt delay cycle by cycle: the interrupt must still be low on the edge that latches the pulse and must be high on the edge after it.

// File: rtl/gfx_irq_pkg.sv
package gfx_irq_pkg;

  localparam int SRC_FRAME = 0;
  localparam int SRC_FLUSH = 1;
  localparam int SRC_OOM   = 2;
  localparam int NUM_SRC   = 3;

  localparam int OFS_PENDING = 'h0;
  localparam int OFS_EN_SET  = 'h4;
  localparam int OFS_EN_CLR  = 'h8;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_PENDING,
    SEL_ENABLE
  } rd_sel_e;

endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
  import gfx_irq_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int NSRC   = 3
) (
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [NSRC-1:0]   pend_clr,
  output logic [NSRC-1:0]   en_set,
  output logic [NSRC-1:0]   en_clr,
  output rd_sel_e           rd_sel
);

  logic hit_pend, hit_set, hit_clr;

  always_comb begin
    hit_pend = (addr == ADDR_W'(OFS_PENDING));
    hit_set  = (addr == ADDR_W'(OFS_EN_SET));
    hit_clr  = (addr == ADDR_W'(OFS_EN_CLR));

    pend_clr = (wr && hit_pend) ? wdata[NSRC-1:0] : '0;
    en_set   = (wr && hit_set)  ? wdata[NSRC-1:0] : '0;
    en_clr   = (wr && hit_clr)  ? wdata[NSRC-1:0] : '0;

    rd_sel = SEL_NONE;
    if (rd) begin
      if (hit_pend)                rd_sel = SEL_PENDING;
      else if (hit_set || hit_clr) rd_sel = SEL_ENABLE;
    end
  end

endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int              NSRC       = 3,
  parameter logic [NSRC-1:0] LEVEL_MASK = 3'b100
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src,
  input  logic [NSRC-1:0] clr,
  output logic [NSRC-1:0] pending
);

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    if (LEVEL_MASK[i]) begin : g_level
      // A level source is resampled on every edge. While the condition is
      // present, it outweighs any acknowledge.
      always_ff @(posedge clk) begin
        if (rst) pending[i] <= 1'b0;
        else     pending[i] <= src[i] | (pending[i] & ~clr[i]);
      end

      a_r7_level_held: assert property (@(posedge clk) disable iff (rst)
        src[i] |=> pending[i]);
    end else begin : g_event
      always_ff @(posedge clk) begin
        if (rst)         pending[i] <= 1'b0;
        else if (src[i]) pending[i] <= 1'b1;
        else if (clr[i]) pending[i] <= 1'b0;
      end

      a_r6_event_holds: assert property (@(posedge clk) disable iff (rst)
        (pending[i] && !clr[i]) |=> pending[i]);
    end

    a_r8_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
      (src[i] && clr[i]) |=> pending[i]);
    a_r2_ack_clears: assert property (@(posedge clk) disable iff (rst)
      (clr[i] && !src[i]) |=> !pending[i]);
  end

endmodule

// File: rtl/irq_enable_mask.sv
module irq_enable_mask #(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] set_bits,
  input  logic [NSRC-1:0] clr_bits,
  output logic [NSRC-1:0] mask
);

  always_ff @(posedge clk) begin
    if (rst) mask <= '0;
    else     mask <= (mask | set_bits) & ~clr_bits;
  end

  a_r3_set_enables: assert property (@(posedge clk) disable iff (rst)
    (set_bits != '0) |=> ((mask & $past(set_bits)) == $past(set_bits)));
  a_r4_clear_disables: assert property (@(posedge clk) disable iff (rst)
    (clr_bits != '0) |=> ((mask & $past(clr_bits)) == '0));
  a_r3_zero_write_keeps: assert property (@(posedge clk) disable iff (rst)
    (set_bits == '0 && clr_bits == '0) |=> $stable(mask));

endmodule

// File: rtl/gfx_irq_ctrl.sv
module gfx_irq_ctrl
  import gfx_irq_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              evt_frame_done,
  input  logic              evt_flush_done,
  input  logic              lvl_out_of_mem,
  output logic              irq_o
);

  localparam int              NSRC     = NUM_SRC;
  localparam logic [NSRC-1:0] LVL_MASK = NSRC'(1) << SRC_OOM;

  logic [NSRC-1:0] src_vec, pend_clr, en_set, en_clr, pending, en_mask;
  rd_sel_e         rd_sel;

  always_comb begin
    src_vec            = '0;
    src_vec[SRC_FRAME] = evt_frame_done;
    src_vec[SRC_FLUSH] = evt_flush_done;
    src_vec[SRC_OOM]   = lvl_out_of_mem;
  end

  irq_bus_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NSRC(NSRC)) u_dec (
    .wr(bus_wr), .rd(bus_rd), .addr(bus_addr), .wdata(bus_wdata),
    .pend_clr(pend_clr), .en_set(en_set), .en_clr(en_clr), .rd_sel(rd_sel)
  );

  irq_status_bank #(.NSRC(NSRC), .LEVEL_MASK(LVL_MASK)) u_stat (
    .clk(clk), .rst(rst), .src(src_vec), .clr(pend_clr), .pending(pending)
  );

  irq_enable_mask #(.NSRC(NSRC)) u_en (
    .clk(clk), .rst(rst), .set_bits(en_set), .clr_bits(en_clr), .mask(en_mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_o     <= 1'b0;
    end else begin
      irq_o <= |(pending & en_mask);
      case (rd_sel)
        SEL_PENDING: bus_rdata <= DATA_W'(pending);
        SEL_ENABLE:  bus_rdata <= DATA_W'(en_mask);
        default:     if (bus_rd) bus_rdata <= '0;
      endcase
    end
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (pending == '0 && en_mask == '0 && !irq_o));
  a_r9_irq_registered: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == $past(|(pending & en_mask))));
  a_r5_upper_zero: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[DATA_W-1:NSRC] == '0);

endmodule

// File: tb/gfx_irq_ctrl_tb.sv
`timescale 1ns/1ps
module gfx_irq_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        evt_frame_done = 1'b0, evt_flush_done = 1'b0, lvl_out_of_mem = 1'b0;
  logic        irq_o;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  gfx_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_frame_done(evt_frame_done),
    .evt_flush_done(evt_flush_done), .lvl_out_of_mem(lvl_out_of_mem), .irq_o(irq_o)
  );

  // Layout: [46:44] src {oom,flush,frame}, [43] wr, [42:39] addr, [38:7] wdata,
  //         [6:4] expected pending, [3:1] expected mask, [0] expected irq
  localparam int NV = 15;
  localparam logic [46:0] VEC [NV] = '{
    {3'b001, 1'b0, 4'h0, 32'h0000_0000, 3'b001, 3'b000, 1'b0}, // R6 latch while disabled
    {3'b000, 1'b1, 4'h4, 32'h0000_0001, 3'b001, 3'b001, 1'b1}, // R3 R9
    {3'b000, 1'b1, 4'h4, 32'h0000_0006, 3'b001, 3'b111, 1'b1}, // R3
    {3'b000, 1'b1, 4'h8, 32'h0000_0001, 3'b001, 3'b110, 1'b0}, // R4 R9
    {3'b010, 1'b0, 4'h0, 32'h0000_0000, 3'b011, 3'b110, 1'b1}, // R6 flush
    {3'b000, 1'b1, 4'h0, 32'h0000_0002, 3'b001, 3'b110, 1'b0}, // R2
    {3'b100, 1'b0, 4'h0, 32'h0000_0000, 3'b101, 3'b110, 1'b1}, // R7 level
    {3'b100, 1'b1, 4'h0, 32'h0000_0007, 3'b100, 3'b110, 1'b1}, // R7 R10 oom held
    {3'b000, 1'b1, 4'h0, 32'h0000_0004, 3'b000, 3'b110, 1'b0}, // R7 ack after drop
    {3'b001, 1'b1, 4'h0, 32'h0000_0001, 3'b001, 3'b110, 1'b0}, // R8
    {3'b000, 1'b1, 4'h0, 32'h0000_0000, 3'b001, 3'b110, 1'b0}, // R2 zero write
    {3'b000, 1'b1, 4'h4, 32'h0000_0000, 3'b001, 3'b110, 1'b0}, // R3 zero write
    {3'b000, 1'b1, 4'h8, 32'h0000_0000, 3'b001, 3'b110, 1'b0}, // R4 zero write
    {3'b000, 1'b1, 4'h4, 32'hFFFF_FFF8, 3'b001, 3'b110, 1'b0}, // R5 upper bits
    {3'b000, 1'b1, 4'h4, 32'h0000_0001, 3'b001, 3'b111, 1'b1}  // R3 R9
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic do_read(input logic [3:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    d = bus_rdata; bus_rd = 1'b0;
  endtask

  task automatic do_write(input logic [3:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  initial begin
    logic [31:0] rv;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    do_read(4'h0, rv); chk("R1 pending", rv, 32'h0);
    do_read(4'h4, rv); chk("R1 mask", rv, 32'h0);
    chk("R1 irq", {31'b0, irq_o}, 32'h0);

    for (int k = 0; k < NV; k++) begin
      logic [46:0] v;
      v = VEC[k];
      evt_frame_done = v[44]; evt_flush_done = v[45]; lvl_out_of_mem = v[46];
      bus_wr = v[43]; bus_addr = v[42:39]; bus_wdata = v[38:7];
      @(negedge clk);
      evt_frame_done = 1'b0; evt_flush_done = 1'b0; bus_wr = 1'b0;
      do_read(4'h0, rv);
      chk($sformatf("R9 irq vec%0d", k), {31'b0, irq_o}, {31'b0, v[0]});
      chk($sformatf("R2/R6/R7 pending vec%0d", k), rv, {29'b0, v[6:4]});
      do_read(4'h4, rv);
      chk($sformatf("R5 mask@set vec%0d", k), rv, {29'b0, v[3:1]});
      do_read(4'h8, rv);
      chk($sformatf("R5 mask@clr vec%0d", k), rv, {29'b0, v[3:1]});
    end

    // R1 reset mid-run with irq high
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R1 irq after reset", {31'b0, irq_o}, 32'h0);
    do_read(4'h0, rv); chk("R1 pending after reset", rv, 32'h0);
    do_read(4'h8, rv); chk("R1 mask after reset", rv, 32'h0);

    // R9 latency: pulse latched at edge N, irq rises at edge N+1
    do_write(4'h4, 32'h1);
    evt_frame_done = 1'b1;
    @(negedge clk);
    evt_frame_done = 1'b0;
    chk("R9 irq not yet", {31'b0, irq_o}, 32'h0);
    @(negedge clk);
    chk("R9 irq raised", {31'b0, irq_o}, 32'h1);

    // R10 clear all with level low
    evt_flush_done = 1'b1;
    @(negedge clk);
    evt_flush_done = 1'b0;
    do_write(4'h0, 32'h7);
    do_read(4'h0, rv); chk("R10 all cleared", rv, 32'h0);
    chk("R10 irq low", {31'b0, irq_o}, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule